// File: doc/BRIEF.md
# Per-Processor Local Interrupt Unit

This block keeps, for each of several processors, the five interrupt sources that belong to that processor alone: a timer, a performance counter, a fast debug channel and two software interrupts. Every processor has its own pending, mask, pin-map and control registers. The pending inputs are registered. A source raises a request when it is both pending and enabled, and the request appears on the processor pin its map register selects. When the control register puts a processor in external-controller mode, the pins stay quiet and the request is presented as a vector number instead.

Software reaches the registers through one access port. The port carries the issuing processor's id and a window select. In the local window the access goes to the issuing processor's own registers. In the other window it goes to the processor named in the issuing processor's other-selector register. Masks change only through bitmap writes to a set port and a clear port. Per-source routability flags decide whether a map register may be reprogrammed. A source that cannot be routed drives a fixed default pin.

Top module: `lcl_irq_unit`

## Requirements
- R1: After reset every mask and control register is zero, each processor's other selector holds its own id, every map register reads 0x80 (map flag set, pin DEF_PIN), and pin_req and vec_out are all zero.
- R2: A write to register 1 (set-mask) sets the mask bit of every source whose data bit is 1 and leaves the rest unchanged. The bit order is 0 timer, 1 performance counter, 2 debug channel, 3 software 0, 4 software 1.
- R3: A write to register 2 (clear-mask) clears the mask bit of every source whose data bit is 1, so writing 0x1F disables all five sources.
- R4: A source requests when its registered pending bit (pend_in captured one clock earlier) and its mask bit are both 1. Its pin is taken from its map register: data bit 7 is the map flag and bits [PIN_W-1:0] are the pin. A source whose map flag is clear drives no pin.
- R5: Control register bits 0 to 3 are the routable flags for timer, performance counter, debug channel and both software sources, in that order. Map writes to a source that is not routable are ignored, and that source drives pin DEF_PIN.
- R6: Control bit 4 selects external-controller mode, in which every source is treated as routable.
- R7: In external-controller mode the processor's pin_req slice is zero, and vec_out carries one plus the highest requested pin, or zero if no pin is requested. In normal mode vec_out is zero.
- R8: A local-window write to register 3 sets the issuing processor's other selector. Other-window accesses to the control, mask and map registers then target the selected processor.
- R9: Other-selector values of NPROC or more are ignored. Accesses whose acc_cpu is NPROC or more change nothing and read zero.
- R10: Other-window writes to register 3 are ignored.
- R11: Register indices are 0 control, 1 set-mask, 2 clear-mask, 3 other selector, 4 to 8 the map registers of sources 0 to 4, and 9 the read-only registered pending bitmap. Set-mask and clear-mask read back the current mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_cpu | input | IDW | Id of the processor issuing the access |
| acc_other | input | 1 | 0 = own registers, 1 = registers of the selected other processor |
| acc_reg | input | 4 | Register index |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Combinational read data |
| pend_in | input | NPROC*5 | Pending sources, 5 bits per processor |
| pin_req | output | NPROC*2**PIN_W | Pin requests, one slice per processor |
| vec_out | output | NPROC*(PIN_W+1) | Vector per processor in external-controller mode |

## Verification
A mask write and a change of a pending input can land on the same clock edge, and the unit has to resolve them together. The bench provokes both orders. In one, a source goes pending on the same edge that a clear-mask write disables it. In the other, a source goes pending on the same edge that a set-mask write enables it. In the first case no pin request may appear in any cycle. In the second case the request must appear in the very next cycle. This shows that the mask and the registered pending bit are both taken from the same edge, not one cycle apart.

// File: rtl/lcl_irq_unit.sv
module lcl_irq_unit #(
  parameter int NPROC   = 3,
  parameter int IDW     = 2,
  parameter int PIN_W   = 3,
  parameter int DEF_PIN = 0
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [IDW-1:0]                acc_cpu,
  input  logic                          acc_other,
  input  logic [3:0]                    acc_reg,
  input  logic                          wr_en,
  input  logic [7:0]                    wr_data,
  output logic [7:0]                    rd_data,
  input  logic [NPROC*5-1:0]            pend_in,
  output logic [NPROC*(2**PIN_W)-1:0]   pin_req,
  output logic [NPROC*(PIN_W+1)-1:0]    vec_out
);
  localparam int NSRC = 5;
  localparam int NPIN = 2**PIN_W;
  localparam int VW   = PIN_W + 1;

  logic [NPROC-1:0][NSRC-1:0]       ctrl_q;
  logic [NPROC-1:0][NSRC-1:0]       mask_q;
  logic [NPROC-1:0][NSRC-1:0]       pend_q;
  logic [NPROC-1:0][IDW-1:0]        other_q;
  logic [NPROC-1:0][NSRC-1:0][7:0]  map_q;

  function automatic logic routable(input logic [NSRC-1:0] c, input int s);
    return c[4] | ((s == 0) ? c[0] : (s == 1) ? c[1] : (s == 2) ? c[2] : c[3]);
  endfunction

  logic           cpu_ok;
  logic [IDW-1:0] cpu_idx;
  logic [IDW-1:0] tgt;
  assign cpu_ok  = int'(acc_cpu) < NPROC;
  assign cpu_idx = cpu_ok ? acc_cpu : '0;
  assign tgt     = acc_other ? other_q[cpu_idx] : cpu_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      mask_q <= '0;
      pend_q <= '0;
      for (int p = 0; p < NPROC; p++) begin
        other_q[p] <= IDW'(p);
        for (int s = 0; s < NSRC; s++) map_q[p][s] <= 8'h80 | 8'(DEF_PIN);
      end
    end else begin
      pend_q <= pend_in;
      if (wr_en && cpu_ok) begin
        case (acc_reg)
          4'd0: ctrl_q[tgt] <= wr_data[NSRC-1:0];
          4'd1: mask_q[tgt] <= mask_q[tgt] | wr_data[NSRC-1:0];
          4'd2: mask_q[tgt] <= mask_q[tgt] & ~wr_data[NSRC-1:0];
          4'd3: if (!acc_other && int'(wr_data) < NPROC) other_q[cpu_idx] <= wr_data[IDW-1:0];
          4'd4, 4'd5, 4'd6, 4'd7, 4'd8:
            if (routable(ctrl_q[tgt], int'(acc_reg) - 4)) map_q[tgt][acc_reg - 4'd4] <= wr_data;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    rd_data = '0;
    if (cpu_ok) begin
      case (acc_reg)
        4'd0: rd_data = 8'(ctrl_q[tgt]);
        4'd1, 4'd2: rd_data = 8'(mask_q[tgt]);
        4'd3: rd_data = 8'(other_q[cpu_idx]);
        4'd4, 4'd5, 4'd6, 4'd7, 4'd8: rd_data = map_q[tgt][acc_reg - 4'd4];
        4'd9: rd_data = 8'(pend_q[tgt]);
        default: rd_data = '0;
      endcase
    end
  end

  logic [NPROC-1:0][NPIN-1:0] pins_c;
  logic [NPROC-1:0][VW-1:0]   vec_c;

  always_comb begin
    pins_c = '0;
    vec_c  = '0;
    for (int p = 0; p < NPROC; p++) begin
      for (int s = 0; s < NSRC; s++) begin
        if (pend_q[p][s] && mask_q[p][s]) begin
          if (!routable(ctrl_q[p], s)) pins_c[p][DEF_PIN] = 1'b1;
          else if (map_q[p][s][7]) pins_c[p][map_q[p][s][PIN_W-1:0]] = 1'b1;
        end
      end
      if (ctrl_q[p][4]) begin
        for (int j = 0; j < NPIN; j++)
          if (pins_c[p][j]) vec_c[p] = VW'(j + 1);
      end
    end
  end

  for (genvar p = 0; p < NPROC; p++) begin : g_out
    assign pin_req[p*NPIN +: NPIN] = ctrl_q[p][4] ? '0 : pins_c[p];
    assign vec_out[p*VW +: VW]     = vec_c[p];
  end
endmodule

// File: rtl/lcl_irq_unit_chk.sv
module lcl_irq_unit_chk #(
  parameter int NPROC = 3,
  parameter int IDW   = 2,
  parameter int PIN_W = 3
) (
  input logic                               clk,
  input logic                               rst_n,
  input logic [IDW-1:0]                     acc_cpu,
  input logic                               acc_other,
  input logic [3:0]                         acc_reg,
  input logic                               wr_en,
  input logic [4:0]                         wr_bits,
  input logic [NPROC*5-1:0]                 pend_in,
  input logic [NPROC*(2**PIN_W)-1:0]        pin_req,
  input logic [NPROC*(PIN_W+1)-1:0]         vec_out,
  input logic [NPROC-1:0][4:0]              ctrl_q,
  input logic [NPROC-1:0][4:0]              mask_q,
  input logic [NPROC-1:0][IDW-1:0]          other_q,
  input logic [NPROC-1:0][4:0][7:0]         map_q
);
  localparam int NPIN = 2**PIN_W;
  localparam int VW   = PIN_W + 1;

  for (genvar p = 0; p < NPROC; p++) begin : g_p
    a_r7_no_pins_in_ext: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_q[p][4] |-> pin_req[p*NPIN +: NPIN] == '0);

    a_r7_vec_needs_ext: assert property (@(posedge clk) disable iff (!rst_n)
      vec_out[p*VW +: VW] != '0 |-> ctrl_q[p][4]);

    a_r4_req_needs_mask: assert property (@(posedge clk) disable iff (!rst_n)
      pin_req[p*NPIN +: NPIN] != '0 |-> ($past(pend_in[p*5 +: 5]) & mask_q[p]) != '0);

    a_r9_other_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      int'(other_q[p]) < NPROC);

    a_r3_clear_all: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !acc_other && acc_reg == 4'd2 && wr_bits == 5'h1F && int'(acc_cpu) == p)
      |=> mask_q[p] == '0);

    a_r5_map_locked: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !acc_other && int'(acc_cpu) == p && acc_reg >= 4'd4 && acc_reg <= 4'd8
       && ctrl_q[p] == '0) |=> $stable(map_q[p]));
  end
endmodule

bind lcl_irq_unit lcl_irq_unit_chk #(.NPROC(NPROC), .IDW(IDW), .PIN_W(PIN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .acc_cpu(acc_cpu), .acc_other(acc_other), .acc_reg(acc_reg),
  .wr_en(wr_en), .wr_bits(wr_data[4:0]), .pend_in(pend_in), .pin_req(pin_req),
  .vec_out(vec_out), .ctrl_q(ctrl_q), .mask_q(mask_q), .other_q(other_q), .map_q(map_q)
);

// File: tb/lcl_irq_unit_tb_top.sv
module lcl_irq_unit_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NPROC = 3;
  localparam int IDW = 2;
  localparam int PIN_W = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [IDW-1:0] acc_cpu = '0;
  logic acc_other = 1'b0;
  logic [3:0] acc_reg = '0;
  logic wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic [NPROC*5-1:0] pend_in = '0;
  logic [NPROC*8-1:0] pin_req;
  logic [NPROC*4-1:0] vec_out;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lcl_irq_unit #(.NPROC(NPROC), .IDW(IDW), .PIN_W(PIN_W), .DEF_PIN(0)) dut_i (
    .clk(clk), .rst_n(rst_n), .acc_cpu(acc_cpu), .acc_other(acc_other), .acc_reg(acc_reg),
    .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data), .pend_in(pend_in),
    .pin_req(pin_req), .vec_out(vec_out));

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(int cpu, bit oth, int r, logic [7:0] d);
    @(negedge clk);
    acc_cpu = IDW'(cpu); acc_other = oth; acc_reg = 4'(r); wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(int cpu, bit oth, int r, output logic [7:0] d);
    acc_cpu = IDW'(cpu); acc_other = oth; acc_reg = 4'(r);
    #1 d = rd_data;
  endtask

  task automatic set_pend(logic [NPROC*5-1:0] v);
    @(negedge clk);
    pend_in = v;
    @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    rd(1, 0, 3, d); chk("R1 other sel of cpu1", d, 1);
    rd(2, 0, 3, d); chk("R1 other sel of cpu2", d, 2);
    rd(0, 0, 1, d); chk("R1 mask", d, 0);
    rd(0, 0, 0, d); chk("R1 ctrl", d, 0);
    rd(2, 0, 6, d); chk("R1 map", d, 8'h80);
    chk("R1 pin_req", pin_req, 0);
    chk("R1 vec_out", vec_out, 0);
  endtask

  task automatic t_mask();
    logic [7:0] d;
    set_pend(15'h001F);
    rd(0, 0, 9, d); chk("R11 pending read", d, 8'h1F);
    wr(0, 0, 1, 8'h05);
    rd(0, 0, 1, d); chk("R2 set-mask bitmap", d, 8'h05);
    chk("R4 R5 default pin request", pin_req[7:0], 8'h01);
    wr(0, 0, 2, 8'h01);
    rd(0, 0, 2, d); chk("R3 clear one bit", d, 8'h04);
    chk("R4 remaining source", pin_req[7:0], 8'h01);
    wr(0, 0, 2, 8'h1F);
    rd(0, 0, 1, d); chk("R3 clear all", d, 8'h00);
    chk("R3 no request", pin_req, 0);
  endtask

  task automatic t_route();
    logic [7:0] d;
    wr(0, 0, 5, 8'h83);
    rd(0, 0, 5, d); chk("R5 map write ignored", d, 8'h80);
    wr(0, 0, 0, 8'h02);
    rd(0, 0, 0, d); chk("R11 ctrl read", d, 8'h02);
    wr(0, 0, 5, 8'h83);
    rd(0, 0, 5, d); chk("R5 map write accepted", d, 8'h83);
    wr(0, 0, 1, 8'h02);
    chk("R4 mapped pin 3", pin_req[7:0], 8'h08);
    wr(0, 0, 5, 8'h03);
    chk("R4 map flag clear", pin_req[7:0], 8'h00);
    wr(0, 0, 0, 8'h00);
    chk("R5 unroutable uses default", pin_req[7:0], 8'h01);
    wr(0, 0, 2, 8'h1F);
  endtask

  task automatic t_ext();
    logic [7:0] d;
    wr(0, 0, 0, 8'h10);
    wr(0, 0, 7, 8'h85);
    rd(0, 0, 7, d); chk("R6 map accepted in ext mode", d, 8'h85);
    wr(0, 0, 1, 8'h0A);
    chk("R7 vector pin5", vec_out[3:0], 4'd6);
    chk("R7 pins quiet", pin_req[7:0], 8'h00);
    wr(0, 0, 4, 8'h82);
    wr(0, 0, 1, 8'h01);
    chk("R7 highest pin wins", vec_out[3:0], 4'd6);
    wr(0, 0, 7, 8'h05);
    chk("R7 next pin", vec_out[3:0], 4'd3);
    wr(0, 0, 0, 8'h00);
    chk("R7 normal mode vec zero", vec_out[3:0], 4'd0);
    chk("R5 back to default pin", pin_req[7:0], 8'h01);
    wr(0, 0, 2, 8'h1F);
    set_pend('0);
  endtask

  task automatic t_other();
    logic [7:0] d;
    wr(0, 0, 3, 8'h02);
    rd(0, 0, 3, d); chk("R8 selector set", d, 2);
    wr(0, 1, 1, 8'h10);
    rd(2, 0, 1, d); chk("R8 other mask target", d, 8'h10);
    rd(0, 0, 1, d); chk("R8 own mask untouched", d, 0);
    rd(0, 1, 1, d); chk("R8 other window read", d, 8'h10);
    wr(0, 0, 3, 8'h03);
    rd(0, 0, 3, d); chk("R9 out of range id ignored", d, 2);
    wr(0, 1, 3, 8'h01);
    rd(0, 0, 3, d); chk("R10 other-window selector write", d, 2);
    rd(2, 0, 3, d); chk("R10 target selector kept", d, 2);
    wr(3, 0, 1, 8'h1F);
    rd(3, 0, 1, d); chk("R9 bad cpu reads zero", d, 0);
    rd(0, 0, 1, d); chk("R9 cpu0 untouched", d, 0);
    rd(1, 0, 1, d); chk("R9 cpu1 untouched", d, 0);
    wr(0, 1, 0, 8'h10);
    rd(2, 0, 0, d); chk("R8 other ctrl target", d, 8'h10);
    set_pend(15'h4000);
    chk("R7 cpu2 vector", vec_out[11:8], 4'd1);
    wr(2, 0, 2, 8'h1F);
    wr(2, 0, 0, 8'h00);
    set_pend('0);
  endtask

  task automatic t_collide();
    @(negedge clk);
    acc_cpu = 1; acc_other = 0; acc_reg = 4'd1; wr_data = 8'h01; wr_en = 1'b1;
    @(negedge clk);
    acc_reg = 4'd2; pend_in = 15'h0020;
    @(negedge clk);
    wr_en = 1'b0;
    chk("R4 pend and clear same edge", pin_req[15:8], 8'h00);
    @(negedge clk);
    chk("R4 still masked", pin_req[15:8], 8'h00);
    pend_in = '0;
    @(negedge clk);
    acc_reg = 4'd1; pend_in = 15'h0020; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    chk("R4 pend and set same edge", pin_req[15:8], 8'h01);
    wr(1, 0, 2, 8'h1F);
    chk("R3 cleared after collision", pin_req[15:8], 8'h00);
    set_pend('0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_mask();
    t_route();
    t_ext();
    t_other();
    t_collide();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule